// File: doc/BRIEF.md
# Interleaved Banked Byte Memory

A byte-addressable storage block made of 2^BANK_W independent banks, each 2^OFF_W entries of one byte. With BANK_W=4 and OFF_W=11 it forms sixteen 2K x 8 banks and a 32K-byte space addressed by 15 bits. The bank-select field of the address can be switched at run time. In high-order interleaving the top address bits pick the bank. In low-order interleaving the bottom address bits pick the bank.

A request carries a byte address, a size code, a write flag and up to eight bytes of write data. The request is accepted through a valid/ready handshake. A multi-byte word is named by its lowest byte address and is stored little-endian. Every multi-byte request is checked for natural alignment, and a misaligned request is refused with an error response and no write. In low-order mode the bytes of one word lie in distinct banks and move in a single cycle. In high-order mode they share one bank and move one byte per cycle.

Top module: `ilv_byte_mem`

## Requirements
- R1: With hi_mode=1 at acceptance, byte address a maps to bank a[AW-1:OFF_W] and to offset a[OFF_W-1:0], where AW=BANK_W+OFF_W.
- R2: With hi_mode=0 at acceptance, byte address a maps to bank a[BANK_W-1:0] and to offset a[AW-1:BANK_W].
- R3: The size code req_size values 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The bytes come from consecutive addresses starting at req_addr and are packed little-endian: the byte at req_addr is in bits [7:0], and bits above the access size read as zero.
- R4: A request whose address is not a multiple of its byte count gives a response one cycle after acceptance with rsp_misalign=1 and rsp_rdata=0, and it writes no bank.
- R5: In low-order mode, and for any aligned request, the whole access completes at the accepting edge. rsp_valid is high in the following cycle, and req_ready stays high throughout.
- R6: In high-order mode, an aligned request of n>1 bytes moves one byte per cycle. req_ready is low for the n-1 cycles after acceptance, and rsp_valid is high n cycles after acceptance, one cycle after the last byte.
- R7: After reset, req_ready=1, rsp_valid=0, rsp_misalign=0 and rsp_rdata=0.
- R8: A write response carries rsp_rdata=0 and rsp_misalign=0.
- R9: A single-byte request in high-order mode completes in one cycle, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_mode | input | 1 | 1 = bank from top address bits, 0 = bank from bottom bits; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Byte count code: 0=1, 1=2, 2=4, 3=8 |
| req_addr | input | BANK_W+OFF_W | Lowest byte address of the access |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_misalign | output | 1 | Response refused for misalignment |
| rsp_rdata | output | 64 | Read data, little-endian, zero-extended |

## Verification
The bench uses BANK_W=4 and OFF_W=7, which gives sixteen banks of 128 bytes and an 11-bit address. This keeps the storage small while leaving the bank field as wide as in the full 32K layout. Sixteen banks is enough for an aligned 8-byte word to spread over eight distinct banks in low-order mode. The two address splits are compared by writing in one mode and reading back, in the other mode, the address that should land in the same bank and offset. Stall length and response latency are counted at the ports for every size, and refused requests are followed by reads that show storage unchanged.

// File: rtl/ilv_byte_mem.sv
module ilv_byte_mem #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 7,
  localparam int AW    = BANK_W + OFF_W,
  localparam int NBANK = 1 << BANK_W,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_misalign,
  output logic [63:0]   rsp_rdata
);

  function automatic logic [BANK_W-1:0] bank_of(input logic [AW-1:0] a, input logic hi);
    return hi ? a[AW-1 -: BANK_W] : a[BANK_W-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [AW-1:0] a, input logic hi);
    return hi ? a[OFF_W-1:0] : a[AW-1 -: OFF_W];
  endfunction

  logic [7:0] mem [NBANK][DEPTH];

  logic          busy, s_write;
  logic [2:0]    cnt, s_last;
  logic [AW-1:0] s_addr;
  logic [63:0]   s_wdata, acc;

  logic [3:0]    nbytes;
  logic [AW-1:0] amask;
  logic          accept, mis, multi_hi;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign nbytes    = 4'd1 << req_size;
  assign amask     = AW'(nbytes - 4'd1);
  assign mis       = |(req_addr & amask);
  assign multi_hi  = hi_mode && (req_size != 2'd0);

  logic [BANK_W-1:0] lane_bank [8];
  logic [OFF_W-1:0]  lane_off  [8];
  logic [63:0]       rd_all;

  for (genvar g = 0; g < 8; g++) begin : g_lane
    logic [AW-1:0] la;
    assign la           = req_addr + AW'(g);
    assign lane_bank[g] = bank_of(la, hi_mode);
    assign lane_off[g]  = off_of(la, hi_mode);
    assign rd_all[8*g +: 8] = (4'(g) < nbytes) ? mem[lane_bank[g]][lane_off[g]] : 8'h00;
  end

  logic [AW-1:0]     cur_addr;
  logic [BANK_W-1:0] cur_bank;
  logic [OFF_W-1:0]  cur_off;
  logic [7:0]        cur_byte;

  assign cur_addr = s_addr + AW'(cnt);
  assign cur_bank = bank_of(cur_addr, 1'b1);
  assign cur_off  = off_of(cur_addr, 1'b1);
  assign cur_byte = mem[cur_bank][cur_off];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cnt          <= '0;
      s_last       <= '0;
      s_write      <= 1'b0;
      s_addr       <= '0;
      s_wdata      <= '0;
      acc          <= '0;
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_misalign <= 1'b0;
      if (busy) begin
        if (s_write) mem[cur_bank][cur_off] <= s_wdata[8*cnt +: 8];
        else         acc[8*cnt +: 8] <= cur_byte;
        cnt <= cnt + 3'd1;
        if (cnt == s_last) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= s_write ? 64'h0 : (acc | ({56'h0, cur_byte} << (8*cnt)));
        end
      end else if (accept) begin
        if (mis) begin
          rsp_valid    <= 1'b1;
          rsp_misalign <= 1'b1;
          rsp_rdata    <= '0;
        end else if (multi_hi) begin
          busy    <= 1'b1;
          cnt     <= 3'd1;
          s_last  <= 3'(nbytes - 4'd1);
          s_write <= req_write;
          s_addr  <= req_addr;
          s_wdata <= req_wdata;
          if (req_write) mem[lane_bank[0]][lane_off[0]] <= req_wdata[7:0];
          acc <= {56'h0, mem[lane_bank[0]][lane_off[0]]};
        end else begin
          for (int b = 0; b < 8; b++)
            if (req_write && (4'(b) < nbytes))
              mem[lane_bank[b]][lane_off[b]] <= req_wdata[8*b +: 8];
          rsp_valid <= 1'b1;
          rsp_rdata <= req_write ? 64'h0 : rd_all;
        end
      end
    end
  end

  AST_MISALIGN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mis |=> rsp_valid && rsp_misalign && (rsp_rdata == 64'h0)); // R4
  AST_FLAG_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_misalign |-> rsp_valid); // R4
  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mis && !multi_hi |=> rsp_valid && req_ready); // R5
  AST_HI_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mis && multi_hi |=> !req_ready && !rsp_valid); // R6
  AST_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R6
  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && !multi_hi |=> rsp_rdata == 64'h0); // R8

endmodule

// File: tb/test_ilv_byte_mem.sv
module test_ilv_byte_mem;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hi_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid, rsp_misalign;
  logic [63:0]   rsp_rdata;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_byte_mem #(.BANK_W(4), .OFF_W(7)) i_ilv_byte_mem (
    .clk(clk), .rst_n(rst_n), .hi_mode(hi_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_misalign(rsp_misalign), .rsp_rdata(rsp_rdata));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [63:0] d, input logic h,
                        output logic [63:0] rd, output logic mis, output int lat, output int stall);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d; hi_mode = h;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; stall = 0;
    while (!rsp_valid && lat < 40) begin
      if (!req_ready) stall++;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata; mis = rsp_misalign;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R7 ready after reset", 64'(req_ready), 64'd1);
    chk("R7 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R7 misalign after reset", 64'(rsp_misalign), 64'd0);
    chk("R7 rdata after reset", rsp_rdata, 64'd0);
  endtask

  task automatic t_low_rw();
    logic [63:0] rd; logic mis; int lat, st;
    access(1, 2'd3, 11'h040, 64'h8877665544332211, 0, rd, mis, lat, st);
    chk("R5 low write latency", 64'(lat), 64'd1);
    chk("R5 low write no stall", 64'(st), 64'd0);
    chk("R8 write rdata zero", rd, 64'd0);
    chk("R8 write misalign low", 64'(mis), 64'd0);
    access(0, 2'd3, 11'h040, 0, 0, rd, mis, lat, st);
    chk("R3 low read 8B", rd, 64'h8877665544332211);
    chk("R5 low read latency", 64'(lat), 64'd1);
    access(0, 2'd0, 11'h043, 0, 0, rd, mis, lat, st);
    chk("R3 low read 1B", rd, 64'h44);
    access(0, 2'd1, 11'h046, 0, 0, rd, mis, lat, st);
    chk("R3 low read 2B", rd, 64'h8877);
    access(0, 2'd2, 11'h044, 0, 0, rd, mis, lat, st);
    chk("R3 low read 4B", rd, 64'h88776655);
  endtask

  task automatic t_hi_rw();
    logic [63:0] rd; logic mis; int lat, st;
    access(1, 2'd2, 11'h100, 64'hDDCCBBAA, 1, rd, mis, lat, st);
    chk("R6 hi 4B write latency", 64'(lat), 64'd4);
    chk("R6 hi 4B write stall", 64'(st), 64'd3);
    chk("R8 hi write rdata zero", rd, 64'd0);
    access(0, 2'd2, 11'h100, 0, 1, rd, mis, lat, st);
    chk("R6 hi 4B read data", rd, 64'hDDCCBBAA);
    chk("R6 hi 4B read latency", 64'(lat), 64'd4);
    access(0, 2'd0, 11'h102, 0, 1, rd, mis, lat, st);
    chk("R9 hi 1B read data", rd, 64'hCC);
    chk("R9 hi 1B latency", 64'(lat), 64'd1);
    chk("R9 hi 1B no stall", 64'(st), 64'd0);
    access(1, 2'd3, 11'h208, 64'h0123456789ABCDEF, 1, rd, mis, lat, st);
    chk("R6 hi 8B write latency", 64'(lat), 64'd8);
    chk("R6 hi 8B write stall", 64'(st), 64'd7);
    access(0, 2'd3, 11'h208, 0, 1, rd, mis, lat, st);
    chk("R6 hi 8B read data", rd, 64'h0123456789ABCDEF);
    access(0, 2'd1, 11'h20E, 0, 1, rd, mis, lat, st);
    chk("R6 hi 2B read data", rd, 64'h0123);
    chk("R6 hi 2B latency", 64'(lat), 64'd2);
  endtask

  task automatic t_cross_map();
    logic [63:0] rd; logic mis; int lat, st;
    // hi 0x101 -> bank 2 offset 1; low address {offset 1, bank 2} = 0x012
    access(0, 2'd0, 11'h012, 0, 0, rd, mis, lat, st);
    chk("R1 R2 hi write seen in low read", rd, 64'hBB);
    // low 0x035 -> bank 5 offset 3; hi address {bank 5, offset 3} = 0x283
    access(1, 2'd0, 11'h035, 64'h5E, 0, rd, mis, lat, st);
    access(0, 2'd0, 11'h283, 0, 1, rd, mis, lat, st);
    chk("R1 R2 low write seen in hi read", rd, 64'h5E);
    // low 0x209 maps bank 9 offset 0x20; hi bank 9 offset 0x20 = 0x4A0
    access(1, 2'd0, 11'h209, 64'hC3, 0, rd, mis, lat, st);
    access(0, 2'd0, 11'h4A0, 0, 1, rd, mis, lat, st);
    chk("R2 low bank from bottom bits", rd, 64'hC3);
  endtask

  task automatic t_misalign();
    logic [63:0] rd; logic mis; int lat, st;
    access(1, 2'd2, 11'h042, 64'hFFFFFFFF, 0, rd, mis, lat, st);
    chk("R4 low misaligned flag", 64'(mis), 64'd1);
    chk("R4 low misaligned latency", 64'(lat), 64'd1);
    access(0, 2'd3, 11'h040, 0, 0, rd, mis, lat, st);
    chk("R4 no write after misaligned", rd, 64'h8877665544332211);
    chk("R4 aligned read flag clear", 64'(mis), 64'd0);
    access(0, 2'd3, 11'h204, 0, 1, rd, mis, lat, st);
    chk("R4 hi misaligned flag", 64'(mis), 64'd1);
    chk("R4 hi misaligned rdata zero", rd, 64'd0);
    chk("R4 hi misaligned latency", 64'(lat), 64'd1);
    access(1, 2'd1, 11'h101, 64'h9999, 1, rd, mis, lat, st);
    chk("R4 hi 2B misaligned flag", 64'(mis), 64'd1);
    access(0, 2'd2, 11'h100, 0, 1, rd, mis, lat, st);
    chk("R4 hi no write after misaligned", rd, 64'hDDCCBBAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_rw();
    t_hi_rw();
    t_cross_map();
    t_misalign();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule